// File: doc/BRIEF.md
# Sixteen-bit timer channel with selectable count clock and clear source

The block is one 16-bit up-counter. It is configured through a small register write port. A control byte picks three things: the count clock, which edge of that clock counts, and the event that clears the counter.

The count clock can come from two kinds of source:
- **Internal:** a free-running prescaler gives the system clock undivided, or divided by 4, 16 or 64.
- **External:** one of four clock pins. Each pin goes through a two-flop synchronizer before its edges are detected.

A two-state level tracker turns the selected clock level into count enables. Its states are `LVL_LO` and `LVL_HI`. The transition `rise` (LVL_LO to LVL_HI) marks a rising edge and `fall` (LVL_HI to LVL_LO) marks a falling edge.

Four compare registers, A to D, are checked against the counter on each count enable. A match on the register chosen as clear source makes that count step load zero in place of the increment. The counter can also be cleared by a request from another channel when this channel has synchronous operation enabled. When such a channel clears from a compare match, it raises a one-cycle request that other channels can use. Registers C and D can be marked as buffers. A buffer register never matches and never clears the counter.

Top module: `tmr_channel`

Register map on `wr_addr`:

| Address | Register |
|---|---|
| 0 | control byte |
| 1 | mode: bit 0 = sync enable, bit 1 = C is a buffer, bit 2 = D is a buffer |
| 2 | counter |
| 4 to 7 | compare registers A to D |

All registers reset to zero.

## Requirements
- R1: After reset the counter, the match flags and the clear-request output are all zero.
- R2: Control byte fields:
  - bits 7:5 select the clear source;
  - bits 4:3 select the count edge: 00 rising, 01 falling, 1x both;
  - bits 2:0 select the count clock: 000 undivided, 001 divided by 4, 010 divided by 16, 011 divided by 64, 100 to 111 external pins 0 to 3.
- R3: With the undivided clock the counter advances on every clock cycle, whatever the edge field holds.
- R4: With a divided internal clock (prescaler bits 1, 3 and 5 for divide by 4, 16 and 64) the counter advances once per N cycles on a single edge and once per N/2 cycles on both edges.
- R5: An external pin advances the counter once per qualifying edge. The count appears three cycles after the pin changes, and edges on unselected pins have no effect.
- R6: Register A, B, C or D raises its match flag for one cycle after any count enable at which the counter equals it.
- R7: Clear codes 001, 010, 101 and 110 select registers A, B, C and D. A match on the selected register makes that count step load zero instead of incrementing.
- R8: Codes 000 and 100 never clear the counter, and the counter wraps from 0xFFFF to 0x0000.
- R9: A compare register marked as a buffer (C by mode bit 1, D by mode bit 2) gives no match flag and no clear.
- R10: Clear codes 011 and 111 clear the counter in the cycle `sync_clr_in` is high, but only when sync enable is set.
- R11: When sync enable is set and the counter clears from a compare match, `clr_req` is high for exactly the following cycle.
- R12: A counter write takes priority over counting and clearing in the same cycle, and suppresses that cycle's match flags and clear request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address |
| wr_data | input | 16 | write data |
| ext_clk | input | 4 | external clock pins, asynchronous |
| sync_clr_in | input | 1 | clear request from another channel |
| count | output | 16 | counter value |
| match | output | 4 | one-cycle compare match flags, bit 0 = A |
| clr_req | output | 1 | one-cycle clear request to other channels |

## Verification
The assertions assume that every input except the external pins is synchronous to `clk`, and that a write lasts one cycle. They also assume that `sync_clr_in` comes from logic clocked by the same clock. The bench drives every input on the falling edge, keeps each write strobe to one cycle and pulses the sync request for single cycles. Only the external pins toggle freely, and they are treated as asynchronous. Source switches are made with the bench's reference model tracking the same level history, so an edge seen right after a switch counts in both.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        CLR_OFF   = 3'd0,
        CLR_GA    = 3'd1,
        CLR_GB    = 3'd2,
        CLR_SYNC  = 3'd3,
        CLR_OFF2  = 3'd4,
        CLR_GC    = 3'd5,
        CLR_GD    = 3'd6,
        CLR_SYNC2 = 3'd7
    } clr_sel_e;

    typedef enum logic [2:0] {
        SRC_DIV1  = 3'd0,
        SRC_DIV4  = 3'd1,
        SRC_DIV16 = 3'd2,
        SRC_DIV64 = 3'd3,
        SRC_PIN0  = 3'd4,
        SRC_PIN1  = 3'd5,
        SRC_PIN2  = 3'd6,
        SRC_PIN3  = 3'd7
    } clk_src_e;

    typedef enum logic [1:0] {
        EDG_RISE  = 2'd0,
        EDG_FALL  = 2'd1,
        EDG_BOTH  = 2'd2,
        EDG_BOTH2 = 2'd3
    } edge_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;

    typedef struct packed {
        clr_sel_e clr;
        edge_e    edg;
        clk_src_e src;
    } ctrl_t;

    localparam int ADDR_W      = 3;
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_MODE   = 1;
    localparam int ADDR_COUNT  = 2;
    localparam int ADDR_GRBASE = 4;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_GR = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    output ctrl_t                          ctrl,
    output logic                           sync_en,
    output logic                           buf_c,
    output logic                           buf_d,
    output logic [NUM_GR-1:0][CNT_W-1:0]   gr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            sync_en <= 1'b0;
            buf_c   <= 1'b0;
            buf_d   <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) begin
            ctrl <= ctrl_t'(wr_data[7:0]);
        end else if (wr_en && wr_addr == ADDR_W'(ADDR_MODE)) begin
            sync_en <= wr_data[0];
            buf_c   <= wr_data[1];
            buf_d   <= wr_data[2];
        end
    end

    for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                gr[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(ADDR_GRBASE + i))
                gr[i] <= wr_data;
        end
    end

endmodule

// File: rtl/tmr_clk_qual.sv
module tmr_clk_qual
    import tmr_pkg::*;
#(
    parameter int PIN_N = 4,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_src_e         src,
    input  edge_e            edg,
    input  logic [PIN_N-1:0] ext_clk,
    output logic             cnt_en
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PIN_N-1:0] sync1, sync2;
    logic             sel_lvl;
    lvl_state_e       state, state_nx;
    logic             rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            sync1   <= '0;
            sync2   <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
            sync1   <= ext_clk;
            sync2   <= sync1;
        end
    end

    always_comb begin
        unique case (src)
            SRC_DIV1:  sel_lvl = 1'b0;
            SRC_DIV4:  sel_lvl = pre_cnt[1];
            SRC_DIV16: sel_lvl = pre_cnt[3];
            SRC_DIV64: sel_lvl = pre_cnt[5];
            default:   sel_lvl = sync2[src[1:0]];
        endcase
    end

    // level tracker: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= LVL_LO;
        else
            state <= state_nx;
    end

    // level tracker: transitions and edge outputs
    always_comb begin
        state_nx = state;
        rise     = 1'b0;
        fall     = 1'b0;
        unique case (state)
            LVL_LO: if (sel_lvl) begin
                state_nx = LVL_HI;
                rise     = 1'b1;
            end
            LVL_HI: if (!sel_lvl) begin
                state_nx = LVL_LO;
                fall     = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (src == SRC_DIV1)
            cnt_en = 1'b1;
        else begin
            unique case (edg)
                EDG_RISE: cnt_en = rise;
                EDG_FALL: cnt_en = fall;
                default:  cnt_en = rise | fall;
            endcase
        end
    end

    // R4
    div_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && (src == SRC_DIV4 || src == SRC_DIV16 || src == SRC_DIV64))
        |=> !(cnt_en && src == $past(src)));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_GR = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cnt_en,
    input  clr_sel_e                     clr_sel,
    input  logic                         sync_en,
    input  logic                         buf_c,
    input  logic                         buf_d,
    input  logic [NUM_GR-1:0][CNT_W-1:0] gr,
    input  logic                         sync_clr_in,
    input  logic                         cnt_wr,
    input  logic [CNT_W-1:0]             wr_data,
    output logic [CNT_W-1:0]             count,
    output logic [NUM_GR-1:0]            match,
    output logic                         clr_req
);

    logic [NUM_GR-1:0] hit;
    logic              mclr, sclr;

    for (genvar i = 0; i < NUM_GR; i++) begin : g_cmp
        logic blocked;
        if (i == 2)      begin : g_bc assign blocked = buf_c; end
        else if (i == 3) begin : g_bd assign blocked = buf_d; end
        else             begin : g_nb assign blocked = 1'b0;  end
        assign hit[i] = cnt_en && (count == gr[i]) && !blocked;
    end

    always_comb begin
        unique case (clr_sel)
            CLR_GA:  mclr = hit[0];
            CLR_GB:  mclr = hit[1];
            CLR_GC:  mclr = hit[2];
            CLR_GD:  mclr = hit[3];
            default: mclr = 1'b0;
        endcase
        sclr = (clr_sel == CLR_SYNC || clr_sel == CLR_SYNC2) && sync_en && sync_clr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            match   <= '0;
            clr_req <= 1'b0;
        end else begin
            match   <= cnt_wr ? '0 : hit;
            clr_req <= mclr && sync_en && !cnt_wr;
            if (cnt_wr)
                count <= wr_data;
            else if (sclr || mclr)
                count <= '0;
            else if (cnt_en)
                count <= count + 1'b1;
        end
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_wr && !sclr && !mclr) |=> count == $past(count) + 1'b1);

    // R7
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mclr && !cnt_wr) |=> count == '0);

    // R10
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclr && !cnt_wr) |=> count == '0);

    // R9
    buf_c_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match[2] |-> !$past(buf_c));

    // R11
    clr_req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |-> ($past(sync_en) && $past(mclr)));

    // R12
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wr_data) && match == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_GR = 4,
    parameter int PIN_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [PIN_N-1:0]  ext_clk,
    input  logic              sync_clr_in,
    output logic [CNT_W-1:0]  count,
    output logic [NUM_GR-1:0] match,
    output logic              clr_req
);

    localparam int PRE_W = 6;

    ctrl_t                        ctrl;
    logic                         sync_en, buf_c, buf_d, cnt_en, cnt_wr;
    logic [NUM_GR-1:0][CNT_W-1:0] gr;

    assign cnt_wr = wr_en && wr_addr == ADDR_W'(ADDR_COUNT);

    tmr_regs #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .sync_en(sync_en),
        .buf_c(buf_c), .buf_d(buf_d), .gr(gr)
    );

    tmr_clk_qual #(.PIN_N(PIN_N), .PRE_W(PRE_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .src(ctrl.src), .edg(ctrl.edg),
        .ext_clk(ext_clk), .cnt_en(cnt_en)
    );

    tmr_core #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_sel(ctrl.clr),
        .sync_en(sync_en), .buf_c(buf_c), .buf_d(buf_d), .gr(gr),
        .sync_clr_in(sync_clr_in), .cnt_wr(cnt_wr), .wr_data(wr_data),
        .count(count), .match(match), .clr_req(clr_req)
    );

endmodule

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  ext_clk = '0;
    logic        sync_clr_in = 1'b0;
    logic [15:0] count;
    logic [3:0]  match;
    logic        clr_req;

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    tmr_channel u_tmr_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_clk(ext_clk), .sync_clr_in(sync_clr_in),
        .count(count), .match(match), .clr_req(clr_req)
    );

    // reference model state
    logic [15:0] m_cnt, m_gr [4];
    logic [7:0]  m_ctrl;
    logic [2:0]  m_mode;
    logic [3:0]  m_q1, m_q2, m_match, m_hit;
    logic        m_req, m_prev, m_lvl, m_en, m_rise, m_fall, m_mclr, m_sclr, m_cwr;
    int          m_pre, m_src, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_mode = 0; m_q1 = 0; m_q2 = 0;
            m_match = 0; m_req = 0; m_prev = 0; m_pre = 0;
            for (int i = 0; i < 4; i++) m_gr[i] = 0;
        end else begin
            m_src = m_ctrl[2:0];
            m_clr = m_ctrl[7:5];
            if (m_src == 0)      m_lvl = 1'b0;
            else if (m_src < 4)  m_lvl = 1'((m_pre >> (2 * m_src - 1)) & 1);
            else                 m_lvl = m_q2[m_src - 4];
            m_rise = m_lvl && !m_prev;
            m_fall = !m_lvl && m_prev;
            if (m_src == 0)               m_en = 1'b1;
            else if (m_ctrl[4:3] == 2'd0) m_en = m_rise;
            else if (m_ctrl[4:3] == 2'd1) m_en = m_fall;
            else                          m_en = m_rise || m_fall;
            m_prev = m_lvl;
            m_q2 = m_q1;
            m_q1 = ext_clk;
            m_pre = (m_pre + 1) % 64;
            for (int i = 0; i < 4; i++)
                m_hit[i] = m_en && (m_cnt == m_gr[i]) &&
                           !(i == 2 && m_mode[1]) && !(i == 3 && m_mode[2]);
            case (m_clr)
                1: m_mclr = m_hit[0];
                2: m_mclr = m_hit[1];
                5: m_mclr = m_hit[2];
                6: m_mclr = m_hit[3];
                default: m_mclr = 1'b0;
            endcase
            m_sclr = (m_clr == 3 || m_clr == 7) && m_mode[0] && sync_clr_in;
            m_cwr = wr_en && wr_addr == 3'd2;
            m_match = m_cwr ? 4'd0 : m_hit;
            m_req = m_mclr && m_mode[0] && !m_cwr;
            if (m_cwr)                 m_cnt = wr_data;
            else if (m_sclr || m_mclr) m_cnt = 0;
            else if (m_en)             m_cnt = m_cnt + 16'd1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_ctrl = wr_data[7:0];
                    3'd1: m_mode = wr_data[2:0];
                    3'd4, 3'd5, 3'd6, 3'd7: m_gr[wr_addr - 3'd4] = wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // compared on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(count, m_cnt, "count");
            check({12'd0, match}, {12'd0, m_match}, "match");
            check({15'd0, clr_req}, {15'd0, m_req}, "clr_req");
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input int clr, input int edg, input int src);
        wr(3'd0, {8'd0, 3'(clr), 2'(edg), 3'(src)});
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input int n);
        for (int i = 1; i <= n; i++) begin
            if (i % 5 == 0) ext_clk[2] = ~ext_clk[2];
            if (i % 3 == 0) ext_clk[0] = ~ext_clk[0];
            if (i % 7 == 0) ext_clk[1] = ~ext_clk[1];
            if (i % 11 == 0) ext_clk[3] = ~ext_clk[3];
            @(negedge clk);
        end
    endtask

    task automatic sync_pulse();
        sync_clr_in = 1'b1;
        @(negedge clk);
        sync_clr_in = 1'b0;
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        run(3);
        // R1: reset values
        cur_req = "R1";
        check(count, 16'd0, "reset count");
        check({12'd0, match}, 16'd0, "reset match");
        check({15'd0, clr_req}, 16'd0, "reset clr_req");
        rst_n = 1'b1;
        run(4);

        // R2, R3: undivided clock, edge field set to both, ignored
        cur_req = "R3";
        set_ctrl(0, 2, 0);
        run(20);
        set_ctrl(0, 1, 0);
        run(10);

        // R6, R7: clear on A
        cur_req = "R7";
        wr(3'd4, 16'd5);
        wr(3'd2, 16'd0);
        set_ctrl(1, 0, 0);
        run(30);

        // R4: divided internal clocks with each edge mode, clear on B
        cur_req = "R4";
        wr(3'd5, 16'd3);
        set_ctrl(2, 0, 1);
        run(60);
        set_ctrl(2, 1, 2);
        run(200);
        set_ctrl(0, 2, 3);
        run(400);
        set_ctrl(0, 3, 1);
        run(40);

        // R5: external pins, other pins toggling too
        cur_req = "R5";
        wr(3'd2, 16'd0);
        set_ctrl(0, 0, 6);
        pins(200);
        set_ctrl(0, 2, 4);
        pins(120);
        set_ctrl(0, 1, 7);
        pins(150);

        // R9: buffer mode blocks C and D
        cur_req = "R9";
        wr(3'd6, 16'd4);
        wr(3'd7, 16'd6);
        wr(3'd1, 16'd2);
        wr(3'd2, 16'd0);
        set_ctrl(5, 0, 0);
        run(20);
        check(count > 16'd10 ? 16'd1 : 16'd0, 16'd1, "buffered C did not clear");
        cur_req = "R6";
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd0);
        run(20);
        check(count <= 16'd4 ? 16'd1 : 16'd0, 16'd1, "C clears when not buffered");
        cur_req = "R9";
        wr(3'd1, 16'd4);
        set_ctrl(6, 0, 0);
        wr(3'd2, 16'd0);
        run(20);
        check(count > 16'd10 ? 16'd1 : 16'd0, 16'd1, "buffered D did not clear");
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd0);
        run(20);

        // R10: sync clear only with sync enable
        cur_req = "R10";
        set_ctrl(7, 0, 0);
        wr(3'd2, 16'd100);
        run(3);
        sync_sample_off: begin
            sync_pulse();
            check(count == 16'd0 ? 16'd1 : 16'd0, 16'd0, "sync ignored when disabled");
        end
        wr(3'd1, 16'd1);
        run(3);
        sync_pulse();
        check(count, 16'd0, "sync clear code 7");
        set_ctrl(3, 0, 0);
        run(5);
        sync_pulse();
        check(count, 16'd0, "sync clear code 3");
        run(5);

        // R11: clear request from B match with sync enabled
        cur_req = "R11";
        wr(3'd5, 16'd2);
        set_ctrl(2, 0, 0);
        wr(3'd2, 16'd0);
        run(20);
        wr(3'd1, 16'd0);
        run(10);

        // R8: wrap and the two no-clear codes
        cur_req = "R8";
        set_ctrl(0, 0, 0);
        wr(3'd2, 16'hFFF0);
        run(30);
        set_ctrl(4, 0, 0);
        wr(3'd2, 16'hFFFA);
        run(20);

        // R12: counter writes win over counting and clearing
        cur_req = "R12";
        wr(3'd1, 16'd1);
        wr(3'd4, 16'h1237);
        set_ctrl(1, 0, 0);
        for (int k = 0; k < 6; k++) begin
            wr(3'd2, 16'h1234 + 16'(k));
            check(count, 16'h1234 + 16'(k), "write wins");
            run(2);
        end
        wr(3'd2, 16'h1237);
        check(count, 16'h1237, "write at match value");
        run(10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule